// File: doc/BRIEF.md
# UART Line Status and Modem Control

This block holds the line status word and the modem control state of a 16550-class serial port. The receiver hands it each incoming character's parity, framing and break flags as the character is written into the receive queue. The block keeps a three-bit tag for every queue slot, follows the queue's occupancy through push and pop strobes, and builds the 8-bit status word from that state and from the transmit-side empty flags. The serial shifters, the baud divider and the character storage live elsewhere.

The host writes the modem control byte and reads the status word. Modem control bits drive the active-low DTR, RTS and OUT1 pins. With automatic flow control, RTS is also withdrawn while the receive queue holds more than a programmed trigger level. In loopback the pins are parked high and the control bits are fed back to the modem status path.

Top module: `uart_lsr_mcr`

## Requirements
- R1: After reset the modem control byte reads 00h, dtr_n, rts_n and out1_n are high, and the status word reads 60h while the transmit empty inputs are high.
- R2: Status bit 0 is 1 exactly while the receive queue holds a character. With the queues disabled the queue holds one character.
- R3: A push arriving at a full queue is discarded (occupancy unchanged) and sets status bit 1. That bit clears in the cycle after a status read.
- R4: Status bits 2, 3 and 4 show the parity, framing and break flags of the character at the head of the queue, and read 0 when the queue is empty.
- R5: Status bit 7 sets one cycle after a character with any error flag is stored while the queues are enabled. It is always 0 with the queues disabled.
- R6: A status read clears bit 7 only if no stored entry other than the head carries an error flag. Otherwise bit 7 stays set.
- R7: Status bit 5 is the transmit-queue empty input when the queues are enabled, and the holding-register empty input when they are disabled. Bit 6 is bit 5 ANDed with shift-register empty.
- R8: Outside loopback, dtr_n, rts_n and out1_n are the inverses of modem control bits 0, 1 and 2.
- R9: When modem control bit 5 is set and the queues are enabled, rts_n is forced high while occupancy exceeds rx_trig.
- R10: With modem control bit 4 set, dtr_n, rts_n and out1_n are high and modem_in equals {bit 2, bit 0, bit 1}. Otherwise modem_in equals the inverted {ri_n, dsr_n, cts_n}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queues enabled |
| rx_push | input | 1 | Receiver stores a character |
| rx_pe | input | 1 | Parity error flag of pushed character |
| rx_fe | input | 1 | Framing error flag of pushed character |
| rx_bi | input | 1 | Break flag of pushed character |
| rx_pop | input | 1 | Host removes the head character |
| rx_trig | input | CNT_W | Receive trigger level for automatic RTS |
| tx_fifo_empty | input | 1 | Transmit queue empty |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| lsr_rd | input | 1 | Host reads the status word this cycle |
| mcr_wr | input | 1 | Host writes the modem control byte |
| mcr_wdata | input | 8 | Modem control write data |
| cts_n | input | 1 | Clear-to-send pin |
| dsr_n | input | 1 | Data-set-ready pin |
| ri_n | input | 1 | Ring indicator pin |
| lsr | output | 8 | Status word |
| mcr | output | 8 | Modem control readback |
| modem_in | output | 3 | Active-high {ri, dsr, cts} seen by modem status logic |
| dtr_n | output | 1 | Data terminal ready pin |
| rts_n | output | 1 | Request to send pin |
| out1_n | output | 1 | Auxiliary output pin |

## Verification
The assertions check on every cycle that loopback parks the pins and routes the control bits, that the overrun and error-summary bits rise only after a push and that the overrun bit drops after a read, and that the data-ready bit changes only on push or pop. They also check that the shift-register flag gates bit 6 and that automatic RTS withdraws the pin above the trigger. Only the bench scenarios show the per-entry tag bookkeeping: whether a read keeps bit 7 when a later entry is errored, which head flags appear after each pop, and that a discarded character is never stored.

// File: rtl/uart_lsr_mcr.sv
module uart_lsr_mcr #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             rx_push,
  input  logic             rx_pe,
  input  logic             rx_fe,
  input  logic             rx_bi,
  input  logic             rx_pop,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             tx_fifo_empty,
  input  logic             thr_empty,
  input  logic             tsr_empty,
  input  logic             lsr_rd,
  input  logic             mcr_wr,
  input  logic [7:0]       mcr_wdata,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             ri_n,
  output logic [7:0]       lsr,
  output logic [7:0]       mcr,
  output logic [2:0]       modem_in,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             out1_n
);

  logic [2:0]       tag [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count, err_cnt;
  logic [5:0]       ctl;
  logic             oe_q, rfe_q;

  wire [CNT_W-1:0] cap      = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  wire             nonempty = (count != '0);
  wire             full     = (count >= cap);
  wire             do_pop   = rx_pop && nonempty;
  wire             do_push  = rx_push && (!full || do_pop);
  wire             push_err = rx_pe | rx_fe | rx_bi;
  wire [2:0]       head_tag = nonempty ? tag[rptr] : 3'b000;
  wire             head_err = |head_tag;
  wire [CNT_W-1:0] others   = err_cnt - CNT_W'(head_err);
  wire             loop     = ctl[4];
  wire             above    = ctl[5] && fifo_en && (count > rx_trig);
  wire             thre     = fifo_en ? tx_fifo_empty : thr_empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) tag[wptr] <= {rx_bi, rx_fe, rx_pe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      err_cnt <= '0;
      oe_q    <= 1'b0;
      rfe_q   <= 1'b0;
      ctl     <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      count   <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      err_cnt <= err_cnt + CNT_W'(do_push && push_err) - CNT_W'(do_pop && head_err);
      if (rx_push && !do_push) oe_q <= 1'b1;
      else if (lsr_rd)         oe_q <= 1'b0;
      if (do_push && push_err && fifo_en)  rfe_q <= 1'b1;
      else if (lsr_rd && others == '0)     rfe_q <= 1'b0;
      if (mcr_wr) ctl <= mcr_wdata[5:0];
    end
  end

  assign lsr      = {rfe_q & fifo_en, thre & tsr_empty, thre, head_tag, oe_q, nonempty};
  assign mcr      = {2'b00, ctl};
  assign dtr_n    = loop | ~ctl[0];
  assign rts_n    = loop | ~ctl[1] | above;
  assign out1_n   = loop | ~ctl[2];
  assign modem_in = loop ? {ctl[2], ctl[0], ctl[1]} : ~{ri_n, dsr_n, cts_n};

endmodule

// File: rtl/uart_lsr_mcr_chk.sv
module uart_lsr_mcr_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             rx_push,
  input logic             rx_pe,
  input logic             rx_fe,
  input logic             rx_bi,
  input logic             rx_pop,
  input logic             lsr_rd,
  input logic             tsr_empty,
  input logic [CNT_W-1:0] rx_trig,
  input logic [CNT_W-1:0] count,
  input logic [7:0]       lsr,
  input logic [7:0]       mcr,
  input logic [2:0]       modem_in,
  input logic             dtr_n,
  input logic             rts_n,
  input logic             out1_n
);

  p_loop_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[4] |-> (dtr_n && rts_n && out1_n));

  p_loop_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[4] |-> (modem_in == {mcr[2], mcr[0], mcr[1]}));

  p_oe_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsr[1]) |-> $past(rx_push));

  p_oe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[1] && lsr_rd && !rx_push) |=> !lsr[1]);

  p_dr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[0] && !rx_pop) |=> lsr[0]);

  p_dr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr[0] && !rx_push) |=> !lsr[0]);

  p_rfe_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lsr[7]) && $stable(fifo_en)) |-> $past(rx_push && (rx_pe || rx_fe || rx_bi)));

  p_temt_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> (tsr_empty && lsr[5]));

  p_auto_rts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mcr[5] && (count > rx_trig)) |-> rts_n);

endmodule

bind uart_lsr_mcr uart_lsr_mcr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_push(rx_push),
  .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi), .rx_pop(rx_pop),
  .lsr_rd(lsr_rd), .tsr_empty(tsr_empty), .rx_trig(rx_trig), .count(count),
  .lsr(lsr), .mcr(mcr), .modem_in(modem_in),
  .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n)
);

// File: tb/uart_lsr_mcr_bench.sv
module uart_lsr_mcr_bench;
  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NV = 8;
  // {mcr byte, cts_n dsr_n ri_n, exp dtr_n rts_n out1_n, exp modem_in}
  localparam logic [16:0] VEC [NV] = '{
    {8'h01, 3'b111, 3'b011, 3'b000},
    {8'h02, 3'b011, 3'b101, 3'b001},
    {8'h04, 3'b100, 3'b110, 3'b110},
    {8'h07, 3'b111, 3'b000, 3'b000},
    {8'h17, 3'b111, 3'b111, 3'b111},
    {8'h11, 3'b000, 3'b111, 3'b010},
    {8'h12, 3'b000, 3'b111, 3'b001},
    {8'h00, 3'b000, 3'b111, 3'b111}
  };

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, rx_push = 0, rx_pe = 0, rx_fe = 0, rx_bi = 0, rx_pop = 0;
  logic [CNT_W-1:0] rx_trig = '0;
  logic tx_fifo_empty = 1, thr_empty = 1, tsr_empty = 1, lsr_rd = 0, mcr_wr = 0;
  logic [7:0] mcr_wdata = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1;
  logic [7:0] lsr, mcr;
  logic [2:0] modem_in;
  logic dtr_n, rts_n, out1_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_lsr_mcr #(.DEPTH(DEPTH)) u_uart_lsr_mcr (.*);

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic pe, logic fe, logic bi);
    rx_push = 1; rx_pe = pe; rx_fe = fe; rx_bi = bi;
    cyc();
    rx_push = 0; rx_pe = 0; rx_fe = 0; rx_bi = 0;
  endtask

  task automatic pop();
    rx_pop = 1; cyc(); rx_pop = 0;
  endtask

  task automatic rd();
    lsr_rd = 1; cyc(); lsr_rd = 0;
  endtask

  task automatic wmcr(logic [7:0] v);
    mcr_wr = 1; mcr_wdata = v; cyc(); mcr_wr = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    chk("R1 lsr", lsr, 8'h60);
    chk("R1 mcr", mcr, 8'h00);
    chk("R1 pins", {5'b0, dtr_n, rts_n, out1_n}, 8'h07);
    rst_n = 1; cyc();

    for (int i = 0; i < NV; i++) begin
      {cts_n, dsr_n, ri_n} = VEC[i][8:6];
      wmcr(VEC[i][16:9]);
      chk("R8/R10 pins", {5'b0, dtr_n, rts_n, out1_n}, {5'b0, VEC[i][5:3]});
      chk("R10 modem_in", {5'b0, modem_in}, {5'b0, VEC[i][2:0]});
      chk("R8 mcr readback", mcr, VEC[i][16:9]);
    end
    {cts_n, dsr_n, ri_n} = 3'b111;

    fifo_en = 1;
    push(0, 0, 0); chk("R2 data ready", lsr, 8'h61);
    push(1, 0, 0); chk("R5 rfe set, R4 head clean", lsr, 8'hE1);
    rd();          chk("R6 later error keeps rfe", lsr, 8'hE1);
    pop();         chk("R4 head parity", lsr, 8'hE5);
    rd();          chk("R6 head-only error clears", lsr, 8'h65);
    push(0, 1, 0); chk("R5 rfe set again", lsr, 8'hE5);
    pop();         chk("R4 head framing", lsr, 8'hE9);
    pop();         chk("R4 empty, rfe sticky", lsr, 8'hE0);
    rd();          chk("R6 no errors clears", lsr, 8'h60);
    push(0, 0, 1); chk("R4 head break", lsr, 8'hF1);
    pop(); rd();   chk("R6 drained", lsr, 8'h60);

    for (int i = 0; i < DEPTH; i++) push(0, 0, 0);
    chk("R2 full", lsr, 8'h61);
    push(1, 1, 1); chk("R3 overrun set", lsr, 8'h63);
    for (int i = 0; i < DEPTH; i++) pop();
    chk("R3 discarded char not stored", lsr, 8'h62);
    rd();          chk("R3 overrun cleared by read", lsr, 8'h60);

    rx_trig = CNT_W'(2);
    wmcr(8'h22);
    push(0, 0, 0); push(0, 0, 0);
    chk("R9 at trigger", {7'b0, rts_n}, 8'h00);
    push(0, 0, 0);
    chk("R9 above trigger", {7'b0, rts_n}, 8'h01);
    fifo_en = 0; #1;
    chk("R9 no gating with queues off", {7'b0, rts_n}, 8'h00);
    fifo_en = 1; wmcr(8'h02);
    chk("R9 no gating without auto", {7'b0, rts_n}, 8'h00);
    pop(); pop(); pop(); wmcr(8'h00);

    fifo_en = 0;
    push(1, 0, 0); chk("R5 no rfe with queues off", lsr, 8'h65);
    push(0, 0, 0); chk("R2 single holding overrun", lsr, 8'h67);
    pop();         chk("R2 holding emptied", lsr, 8'h62);
    rd();          chk("R3 cleared", lsr, 8'h60);

    fifo_en = 1; tx_fifo_empty = 0; thr_empty = 1; tsr_empty = 1; #1;
    chk("R7 queue mode tx busy", lsr, 8'h00);
    tx_fifo_empty = 1; tsr_empty = 0; #1;
    chk("R7 shifter busy", lsr, 8'h20);
    fifo_en = 0; thr_empty = 0; tsr_empty = 1; #1;
    chk("R7 holding busy", lsr, 8'h00);
    thr_empty = 1; #1;
    chk("R7 holding idle", lsr, 8'h60);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule